// File: doc/BRIEF.md
# Dual-Clock FIFO with Five Status Flags

This block is a first-in first-out buffer for 18-bit words, with a write side and a read side that each run on their own clock. Each side has an enable. A write is taken on a write-clock edge while the buffer is not full. A read is taken on a read-clock edge while the buffer is not empty, and the word then appears on the registered read-data output. The two pointers are one bit wider than the address. Each one is Gray coded and crosses to the other clock domain through a two-flop synchronizer.

Five status outputs describe the fill level: empty, almost empty, half full, almost full and full. A mode input chooses the timing of the two "almost" flags. When the mode input is low, each almost flag is registered in its own clock domain. When it is high, each almost flag is decoded combinationally from that domain's pointer registers. A configuration input selects stand-alone operation or depth-expansion operation. In stand-alone operation the shared status output carries half full. In depth-expansion operation the same output carries a one-cycle strobe that tells the next buffer in a chain to take over writing. The address width is a parameter. The default gives 1024 words, and an address width of 13 or 14 gives the deep variants.

Top module: `flagged_dual_clock_fifo`

## Requirements
- R1: After reset: empty=1, almostEmpty=1, full=0, almostFull=0, halfOrXo=0, rdData=0.
- R2: Words leave in the order they were written, with no loss or duplication, across a complete fill and drain.
- R3: empty is updated only on rdClk edges. It is set on the read edge that takes the last stored word. A read while empty is ignored: the read pointer and rdData are unchanged.
- R4: full is updated only on wrClk edges. It is set on the write edge that stores the DEPTH-th word. A write while full is ignored: the write pointer does not move and the word is dropped.
- R5: almostEmpty is 1 when the occupancy seen in the read domain is 7 words or fewer.
- R6: almostFull is 1 when the free space seen in the write domain is 7 words or fewer.
- R7: syncAlmost=1 makes the almost flags follow the pointers in the same cycle. syncAlmost=0 makes them registered, so they change one cycle of their own clock later.
- R8: With depthExpand=0, halfOrXo is the half-full flag: it is 1 when the occupancy exceeds DEPTH/2, evaluated on wrClk.
- R9: With depthExpand=1, halfOrXo is 1 for exactly one wrClk cycle, after the write edge that stores into the last address (DEPTH-1). It is 0 at all other times, whatever the occupancy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write clock |
| rdClk | input | 1 | Read clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| wrEn | input | 1 | Write enable |
| wrData | input | 18 | Write data |
| rdEn | input | 1 | Read enable |
| rdData | output | 18 | Registered read data |
| syncAlmost | input | 1 | 0: almost flags registered; 1: almost flags combinational |
| depthExpand | input | 1 | 0: stand-alone (half full); 1: depth expansion (expansion strobe) |
| empty | output | 1 | Buffer empty (read domain) |
| almostEmpty | output | 1 | Seven or fewer words stored |
| halfOrXo | output | 1 | Half full, or the expansion-out strobe |
| almostFull | output | 1 | Seven or fewer free locations |
| full | output | 1 | Buffer full (write domain) |

## Verification
On every cycle, the assertions check three things: a read while empty leaves the read pointer unchanged, a write while full leaves the write pointer unchanged, and a full buffer always reports half full in stand-alone mode. They also check that the expansion strobe never lasts more than one write cycle. Only the bench scenarios can show the rest: data order across a full fill and drain, the exact word counts at which each threshold flag switches, the one-cycle difference between the two almost-flag modes, and the strobe firing exactly on the write to the last address.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
  // Strobes that the control sends to the storage datapath
  typedef struct packed {
    logic wrCommit;
    logic rdCommit;
  } fifoStrobe_t;
endpackage

// File: rtl/gray_sync.sv
module gray_sync #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/fifo_store.sv
module fifo_store
  import fifo_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 10
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  fifoStrobe_t       strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strobe.wrCommit) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)                rdData <= '0;
    else if (strobe.rdCommit) rdData <= mem[rdAddr];
  end
endmodule

// File: rtl/fifo_ctrl.sv
module fifo_ctrl
  import fifo_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int ALMOST_GAP = 7
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              syncAlmost,
  input  logic              depthExpand,
  output fifoStrobe_t       strobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              empty,
  output logic              almostEmpty,
  output logic              halfOrXo,
  output logic              almostFull,
  output logic              full
);
  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HALF  = DEPTH / 2;

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] fromGray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // Write domain
  logic [PW-1:0] wrBin, wrGray, rdGraySyncW, rdBinW, wrBinNext, wrCount, wrCountNext;
  logic fullR, afReg, hfR, xoR, afComb, wrCommit;

  assign wrCommit    = wrEn & ~fullR;
  assign wrBinNext   = wrBin + PW'(wrCommit);
  assign rdBinW      = fromGray(rdGraySyncW);
  assign wrCount     = wrBin - rdBinW;
  assign wrCountNext = wrBinNext - rdBinW;
  assign afComb      = (PW'(DEPTH) - wrCount) <= PW'(ALMOST_GAP);

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin <= '0; wrGray <= '0; fullR <= 1'b0;
      afReg <= 1'b0; hfR <= 1'b0; xoR <= 1'b0;
    end else begin
      wrBin  <= wrBinNext;
      wrGray <= toGray(wrBinNext);
      fullR  <= toGray(wrBinNext) ==
                {~rdGraySyncW[PW-1:PW-2], rdGraySyncW[PW-3:0]};
      afReg  <= afComb;
      hfR    <= wrCountNext > PW'(HALF);
      xoR    <= wrCommit && (wrBin[ADDR_W-1:0] == {ADDR_W{1'b1}});
    end
  end

  // Read domain
  logic [PW-1:0] rdBin, rdGray, wrGraySyncR, wrBinR, rdBinNext, rdCount;
  logic emptyR, aeReg, aeComb, rdCommit;

  assign rdCommit  = rdEn & ~emptyR;
  assign rdBinNext = rdBin + PW'(rdCommit);
  assign wrBinR    = fromGray(wrGraySyncR);
  assign rdCount   = wrBinR - rdBin;
  assign aeComb    = rdCount <= PW'(ALMOST_GAP);

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin <= '0; rdGray <= '0; emptyR <= 1'b1; aeReg <= 1'b1;
    end else begin
      rdBin  <= rdBinNext;
      rdGray <= toGray(rdBinNext);
      emptyR <= toGray(rdBinNext) == wrGraySyncR;
      aeReg  <= aeComb;
    end
  end

  gray_sync #(.W(PW)) uRdToWr (.clk(wrClk), .rstN(rstN), .din(rdGray), .dout(rdGraySyncW));
  gray_sync #(.W(PW)) uWrToRd (.clk(rdClk), .rstN(rstN), .din(wrGray), .dout(wrGraySyncR));

  assign strobe.wrCommit = wrCommit;
  assign strobe.rdCommit = rdCommit;
  assign wrAddr      = wrBin[ADDR_W-1:0];
  assign rdAddr      = rdBin[ADDR_W-1:0];
  assign empty       = emptyR;
  assign full        = fullR;
  assign almostEmpty = syncAlmost ? aeComb : aeReg;
  assign almostFull  = syncAlmost ? afComb : afReg;
  assign halfOrXo    = depthExpand ? xoR : hfR;
endmodule

// File: rtl/flagged_dual_clock_fifo.sv
module flagged_dual_clock_fifo
  import fifo_pkg::*;
#(
  parameter int DATA_W     = 18,
  parameter int ADDR_W     = 10,
  parameter int ALMOST_GAP = 7
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  input  logic              syncAlmost,
  input  logic              depthExpand,
  output logic              empty,
  output logic              almostEmpty,
  output logic              halfOrXo,
  output logic              almostFull,
  output logic              full
);
  fifoStrobe_t       strobe;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  fifo_ctrl #(.ADDR_W(ADDR_W), .ALMOST_GAP(ALMOST_GAP)) uCtrl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn),
    .syncAlmost(syncAlmost), .depthExpand(depthExpand), .strobe(strobe),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .empty(empty), .almostEmpty(almostEmpty),
    .halfOrXo(halfOrXo), .almostFull(almostFull), .full(full)
  );

  fifo_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uStore (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .strobe(strobe),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/fifo_flag_checker.sv
module fifo_flag_checker #(
  parameter int ADDR_W = 10
) (
  input logic              wrClk,
  input logic              rdClk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic              depthExpand,
  input logic              empty,
  input logic              full,
  input logic              halfOrXo,
  input logic [ADDR_W-1:0] wrPtr,
  input logic [ADDR_W-1:0] rdPtr
);
  // R3: a read while empty does not move the read pointer
  a_r3_no_underrun: assert property (@(posedge rdClk) disable iff (!rstN)
    (empty && rdEn) |=> $stable(rdPtr));

  // R4: a write while full does not move the write pointer
  a_r4_no_overrun: assert property (@(posedge wrClk) disable iff (!rstN)
    (full && wrEn) |=> $stable(wrPtr));

  // R8: a full buffer always reports half full in stand-alone mode
  a_r8_full_is_half: assert property (@(posedge wrClk) disable iff (!rstN)
    (full && !depthExpand) |-> halfOrXo);

  // R9: the expansion strobe lasts one write cycle
  a_r9_xo_single: assert property (@(posedge wrClk) disable iff (!rstN)
    (depthExpand && halfOrXo) |=> (!halfOrXo || !depthExpand));
endmodule

bind flagged_dual_clock_fifo fifo_flag_checker #(.ADDR_W(ADDR_W)) uFlagChk (
  .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn),
  .depthExpand(depthExpand), .empty(empty), .full(full), .halfOrXo(halfOrXo),
  .wrPtr(uCtrl.wrAddr), .rdPtr(uCtrl.rdAddr)
);

// File: tb/sim_flagged_dual_clock_fifo.sv
module sim_flagged_dual_clock_fifo;
  localparam int DW = 18;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;

  logic wrClk = 1'b0, rdClk = 1'b0, rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0, syncAlmost = 1'b1, depthExpand = 1'b0;
  logic [DW-1:0] wrData = '0, rdData;
  logic empty, almostEmpty, halfOrXo, almostFull, full;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #2 wrClk = ~wrClk;               // 250 MHz
  initial begin #1; forever #2 rdClk = ~rdClk; end

  flagged_dual_clock_fifo #(.DATA_W(DW), .ADDR_W(AW)) u0 (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .syncAlmost(syncAlmost), .depthExpand(depthExpand),
    .empty(empty), .almostEmpty(almostEmpty), .halfOrXo(halfOrXo),
    .almostFull(almostFull), .full(full)
  );

  function automatic logic [DW-1:0] pat(input int k);
    return DW'(k * 37 + 5) ^ 18'h2A5A5;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset(input logic mode, input logic cfg);
    rstN = 1'b0; wrEn = 1'b0; rdEn = 1'b0;
    syncAlmost = mode; depthExpand = cfg;
    repeat (4) @(negedge wrClk);
    rstN = 1'b1;
    repeat (2) @(negedge wrClk);
  endtask

  task automatic pushOne(input logic [DW-1:0] d);
    @(negedge wrClk); wrEn = 1'b1; wrData = d;
    @(negedge wrClk); wrEn = 1'b0;
  endtask

  task automatic popOne();
    @(negedge rdClk); rdEn = 1'b1;
    @(negedge rdClk); rdEn = 1'b0;
  endtask

  task automatic settle();
    repeat (8) @(negedge rdClk);
    repeat (8) @(negedge wrClk);
  endtask

  task automatic testReset();
    doReset(1'b0, 1'b0);
    chk(empty == 1'b1,       "R1 empty",       empty, 1);
    chk(almostEmpty == 1'b1, "R1 almostEmpty", almostEmpty, 1);
    chk(full == 1'b0,        "R1 full",        full, 0);
    chk(almostFull == 1'b0,  "R1 almostFull",  almostFull, 0);
    chk(halfOrXo == 1'b0,    "R1 halfOrXo",    halfOrXo, 0);
    chk(rdData == '0,        "R1 rdData",      rdData, 0);
  endtask

  task automatic testSingle();
    doReset(1'b1, 1'b0);
    pushOne(18'h1ABCD);
    settle();
    chk(empty == 1'b0, "R3 empty cleared after write", empty, 0);
    popOne();
    chk(rdData == 18'h1ABCD, "R2 single word", rdData, 18'h1ABCD);
    chk(empty == 1'b1, "R3 empty set on last read edge", empty, 1);
    popOne();                              // read while empty
    chk(rdData == 18'h1ABCD, "R3 read while empty keeps rdData", rdData, 18'h1ABCD);
    pushOne(18'h00777);
    settle();
    popOne();
    chk(rdData == 18'h00777, "R3 read pointer did not move", rdData, 18'h00777);
  endtask

  task automatic testAlmostEmpty(input logic mode);
    doReset(mode, 1'b0);
    for (int k = 0; k < 8; k++) pushOne(pat(k));
    settle();
    chk(almostEmpty == 1'b0, "R5 eight words not almost empty", almostEmpty, 0);
    popOne();
    chk(rdData == pat(0), "R2 first of eight", rdData, pat(0));
    if (mode) begin
      chk(almostEmpty == 1'b1, "R7 comb almostEmpty same cycle", almostEmpty, 1);
    end else begin
      chk(almostEmpty == 1'b0, "R7 registered almostEmpty lags", almostEmpty, 0);
      @(negedge rdClk);
      chk(almostEmpty == 1'b1, "R7 r5 registered almostEmpty next cycle", almostEmpty, 1);
    end
  endtask

  task automatic testFill();
    int bad = 0;
    doReset(1'b1, 1'b0);
    for (int k = 1; k <= DEPTH; k++) begin
      pushOne(pat(k));
      if (k == DEPTH / 2)     chk(halfOrXo == 1'b0,   "R8 at half not set", halfOrXo, 0);
      if (k == DEPTH / 2 + 1) chk(halfOrXo == 1'b1,   "R8 above half set", halfOrXo, 1);
      if (k == DEPTH - 8)     chk(almostFull == 1'b0, "R6 eight free", almostFull, 0);
      if (k == DEPTH - 7)     chk(almostFull == 1'b1, "R6 seven free", almostFull, 1);
      if (k == DEPTH - 1)     chk(full == 1'b0,       "R4 one free", full, 0);
      if (k == DEPTH)         chk(full == 1'b1,       "R4 full on last write", full, 1);
    end
    pushOne(18'h3FFFF);                    // write while full
    chk(full == 1'b1, "R4 still full", full, 1);
    settle();
    for (int k = 1; k <= DEPTH; k++) begin
      popOne();
      if (rdData != pat(k)) begin
        if (bad == 0) $display("FAIL R2 word %0d actual=%0d expected=%0d", k, rdData, pat(k));
        bad++;
      end
    end
    checks++;
    if (bad != 0) fails++;
    chk(empty == 1'b1, "R2 r4 empty after drain, extra word dropped", empty, 1);
    settle();
    chk(full == 1'b0, "R4 full cleared", full, 0);
    chk(almostFull == 1'b0, "R6 almostFull cleared", almostFull, 0);
  endtask

  task automatic testDepth();
    int seen = 0;
    doReset(1'b1, 1'b1);
    for (int k = 1; k < DEPTH; k++) begin
      pushOne(pat(k));
      if (halfOrXo) seen++;
    end
    chk(seen == 0, "R9 no strobe before last address", seen, 0);
    pushOne(pat(DEPTH));
    chk(halfOrXo == 1'b1, "R9 strobe after last address", halfOrXo, 1);
    @(negedge wrClk);
    chk(halfOrXo == 1'b0, "R9 strobe one cycle", halfOrXo, 0);
  endtask

  initial begin
    testReset();
    testSingle();
    testAlmostEmpty(1'b1);
    testAlmostEmpty(1'b0);
    testFill();
    testDepth();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge wrClk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule